// File: doc/BRIEF.md
# Sticky Fault Status and Address Capture

This block records fault events reported by a processor core and keeps them until software has seen them. Single-cycle event pulses from the core raise sticky status flags: one for a fault that was escalated to a hard fault because it could not be taken, and one for a bus error during the vector fetch of exception entry. Two channels, one for memory-management faults and one for bus faults, each latch the address that faulted together with a valid flag. A channel takes only the first address. Later faults on that channel leave the stored address alone until software clears the channel's valid flag.

Software reaches the block through a word-wide register port with separate read and write strobes and a word offset. Status and valid flags are write-one-to-clear. Writing a zero bit leaves the flag as it is. When a fault and a clear land on the same flag in the same cycle, the fault wins. The port has no back-pressure: every strobe is taken in the cycle it is presented. Read data is registered. It appears on the edge that samples the read strobe and holds until the next read.

Register map, by word offset: 0 is the hard-fault status word (bit 30 is the escalation flag, bit 1 is the vector-fetch flag, and every other bit reads 0), 1 is the valid word (bit 0 is the memory-management address valid flag, bit 1 is the bus address valid flag), 2 is the memory-management fault address, and 3 is the bus fault address. Any other offset reads as zero.

Top module: `fault_capture_regs`

## Requirements
- R1: After reset, every status flag, both valid flags and both address registers are 0, and a read at any offset returns 0.
- R2: A pulse on `forced_evt` sets bit 30 of offset 0, and a pulse on `vecttbl_evt` sets bit 1 of offset 0. Each bit stays at 1 across idle cycles until it is cleared.
- R3: A write to offset 0 clears every flag whose data bit is 1 and leaves unchanged every flag whose data bit is 0. A write to offset 1 does the same for the valid flags.
- R4: When a fault event and a write-one-to-clear target the same flag in the same cycle, the flag is 1 afterwards.
- R5: Bits 31, 29:2 and 0 of offset 0 always read 0, and writing 1 to bit 31 has no effect on the flags.
- R6: A `mm_fault` pulse while bit 0 of offset 1 is 0 loads `mm_addr` into offset 2 and sets that valid bit. The address is stored exactly as given, including unaligned byte addresses. Clearing the valid bit leaves the stored address readable.
- R7: While bit 0 of offset 1 is 1, further `mm_fault` pulses do not change offset 2.
- R8: The bus channel behaves like the memory-management channel, using `bus_fault` and `bus_addr`, offset 3 and bit 1 of offset 1. The two channels are independent of each other.
- R9: Offsets 4 and above read 0. Writes to offsets 2 and 3 have no effect.
- R10: `reg_rdata` takes the value the selected register held before the edge that samples `reg_rd`, and it keeps that value while `reg_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| forced_evt | input | 1 | Pulse: fault escalated to hard fault |
| vecttbl_evt | input | 1 | Pulse: bus error on vector fetch |
| mm_fault | input | 1 | Pulse: memory-management fault |
| mm_addr | input | 32 | Address of the memory-management fault |
| bus_fault | input | 1 | Pulse: bus fault with a known address |
| bus_addr | input | 32 | Address of the bus fault |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_ofs | input | OFS_W | Word offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |

## Verification
The status flags are driven with single events, with both events in turn, and with writes whose data holds all zeros, only the reserved bit 31, one flag bit, or all ones. This separates a true write-one-to-clear from a plain store or a clear of the whole word. The address channels receive a first fault and then a second fault at a different address. Runs that clear the valid flag between faults are compared with runs that do not, which shows whether the first address is kept or overwritten. Each channel is driven alone, so a mix-up between the two channels shows up in the other channel's registers. Events that coincide with a clear, or with a read, check that a set beats a clear and that read data shows the value from before the edge.

// File: rtl/fcr_pkg.sv
package fcr_pkg;
  localparam int DW = 32;
  localparam int AW = 32;

  // word offsets of the register map
  localparam int OFS_STATUS  = 0;
  localparam int OFS_VALID   = 1;
  localparam int OFS_MMADDR  = 2;
  localparam int OFS_BUSADDR = 3;

  // status word bit positions (software decodes these)
  localparam int BIT_FORCED = 30;
  localparam int BIT_VTBL   = 1;

  // internal status vector indices
  localparam int NSTAT   = 2;
  localparam int ST_VTBL = 0;
  localparam int ST_FRC  = 1;

  // address capture channels; index is also the bit in the valid word
  localparam int NCH    = 2;
  localparam int CH_MM  = 0;
  localparam int CH_BUS = 1;
endpackage

// File: rtl/fcr_sticky.sv
module fcr_sticky #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  // a set in the same cycle as a clear leaves the flag at 1
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr_i) | set_i;
  end

  assign q_o = q;
endmodule

// File: rtl/fcr_addr_cap.sv
module fcr_addr_cap #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fault_i,
  input  logic [AW-1:0] addr_i,
  input  logic          clr_i,
  output logic          valid_o,
  output logic [AW-1:0] addr_o
);
  logic          valid_q;
  logic [AW-1:0] addr_q;
  logic          take;

  // only the first fault after the flag was cleared is recorded
  assign take = fault_i & ~valid_q;

  fcr_sticky #(.W(1)) u_vld (
    .clk  (clk),
    .rst_n(rst_n),
    .set_i(fault_i),
    .clr_i(clr_i),
    .q_o  (valid_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)    addr_q <= '0;
    else if (take) addr_q <= addr_i;
  end

  assign valid_o = valid_q;
  assign addr_o  = addr_q;
endmodule

// File: rtl/fcr_rd_mux.sv
module fcr_rd_mux
  import fcr_pkg::*;
#(
  parameter int OFS_W = 3
) (
  input  logic [OFS_W-1:0] ofs_i,
  input  logic [NSTAT-1:0] stat_i,
  input  logic [NCH-1:0]   valid_i,
  input  logic [AW-1:0]    mm_addr_i,
  input  logic [AW-1:0]    bus_addr_i,
  output logic [DW-1:0]    data_o
);
  logic [DW-1:0] stat_word;
  logic [DW-1:0] valid_word;

  always_comb begin
    stat_word             = '0;
    stat_word[BIT_FORCED] = stat_i[ST_FRC];
    stat_word[BIT_VTBL]   = stat_i[ST_VTBL];
    valid_word            = '0;
    valid_word[NCH-1:0]   = valid_i;
  end

  always_comb begin
    case (int'(ofs_i))
      OFS_STATUS:  data_o = stat_word;
      OFS_VALID:   data_o = valid_word;
      OFS_MMADDR:  data_o = mm_addr_i;
      OFS_BUSADDR: data_o = bus_addr_i;
      default:     data_o = '0;
    endcase
  end
endmodule

// File: rtl/fault_capture_regs.sv
module fault_capture_regs
  import fcr_pkg::*;
#(
  parameter int OFS_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             forced_evt,
  input  logic             vecttbl_evt,
  input  logic             mm_fault,
  input  logic [AW-1:0]    mm_addr,
  input  logic             bus_fault,
  input  logic [AW-1:0]    bus_addr,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [OFS_W-1:0] reg_ofs,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata
);
  logic             wr_stat, wr_valid;
  logic [NSTAT-1:0] stat_set, stat_clr, stat_q;
  logic [NCH-1:0]   ch_fault, ch_clr, ch_valid;
  logic [AW-1:0]    ch_addr_in [NCH];
  logic [AW-1:0]    ch_addr    [NCH];
  logic [DW-1:0]    rd_data;
  logic [DW-1:0]    rdata_q;

  assign wr_stat  = reg_wr && (int'(reg_ofs) == OFS_STATUS);
  assign wr_valid = reg_wr && (int'(reg_ofs) == OFS_VALID);

  // status flags: bit 31 and reserved bits of the write data are ignored
  always_comb begin
    stat_set          = '0;
    stat_set[ST_FRC]  = forced_evt;
    stat_set[ST_VTBL] = vecttbl_evt;
    stat_clr          = '0;
    stat_clr[ST_FRC]  = wr_stat & reg_wdata[BIT_FORCED];
    stat_clr[ST_VTBL] = wr_stat & reg_wdata[BIT_VTBL];
  end

  fcr_sticky #(.W(NSTAT)) u_stat (
    .clk  (clk),
    .rst_n(rst_n),
    .set_i(stat_set),
    .clr_i(stat_clr),
    .q_o  (stat_q)
  );

  // channel inputs gathered so the capture slices are generated
  always_comb begin
    ch_fault           = '0;
    ch_fault[CH_MM]    = mm_fault;
    ch_fault[CH_BUS]   = bus_fault;
    ch_addr_in[CH_MM]  = mm_addr;
    ch_addr_in[CH_BUS] = bus_addr;
  end

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      assign ch_clr[c] = wr_valid & reg_wdata[c];

      fcr_addr_cap #(.AW(AW)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .fault_i(ch_fault[c]),
        .addr_i (ch_addr_in[c]),
        .clr_i  (ch_clr[c]),
        .valid_o(ch_valid[c]),
        .addr_o (ch_addr[c])
      );
    end
  endgenerate

  fcr_rd_mux #(.OFS_W(OFS_W)) u_mux (
    .ofs_i     (reg_ofs),
    .stat_i    (stat_q),
    .valid_i   (ch_valid),
    .mm_addr_i (ch_addr[CH_MM]),
    .bus_addr_i(ch_addr[CH_BUS]),
    .data_o    (rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      rdata_q <= '0;
    else if (reg_rd) rdata_q <= rd_data;
  end

  assign reg_rdata = rdata_q;
endmodule

// File: rtl/fcr_checker.sv
module fcr_checker #(
  parameter int OFS_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             forced_evt,
  input logic             vecttbl_evt,
  input logic             mm_fault,
  input logic [31:0]      mm_addr,
  input logic             bus_fault,
  input logic [31:0]      bus_addr,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [OFS_W-1:0] reg_ofs,
  input logic [31:0]      reg_wdata,
  input logic [31:0]      reg_rdata,
  input logic             frc_q,
  input logic             vtbl_q,
  input logic             mm_vld,
  input logic [31:0]      mm_q,
  input logic             bus_vld,
  input logic [31:0]      bus_q
);
  logic wr0_frc;
  assign wr0_frc = reg_wr && (reg_ofs == '0) && reg_wdata[30];

  p_set_frc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    forced_evt |=> frc_q);
  p_set_vtbl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vecttbl_evt |=> vtbl_q);
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frc_q && !wr0_frc |=> frc_q);
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr0_frc && !forced_evt |=> !frc_q);
  p_setwins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr0_frc && forced_evt |=> frc_q);
  p_rsvd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && (reg_ofs == '0) |=> (reg_rdata[31] == 1'b0) && (reg_rdata[29:2] == '0) && (reg_rdata[0] == 1'b0));
  p_mm_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mm_fault && !mm_vld |=> mm_vld && (mm_q == $past(mm_addr)));
  p_mm_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mm_vld |=> $stable(mm_q));
  p_bus_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_fault && !bus_vld |=> bus_vld && (bus_q == $past(bus_addr)));
  p_bus_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_vld |=> $stable(bus_q));
  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));
endmodule

bind fault_capture_regs fcr_checker #(.OFS_W(OFS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .forced_evt (forced_evt),
  .vecttbl_evt(vecttbl_evt),
  .mm_fault   (mm_fault),
  .mm_addr    (mm_addr),
  .bus_fault  (bus_fault),
  .bus_addr   (bus_addr),
  .reg_wr     (reg_wr),
  .reg_rd     (reg_rd),
  .reg_ofs    (reg_ofs),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .frc_q      (stat_q[1]),
  .vtbl_q     (stat_q[0]),
  .mm_vld     (ch_valid[0]),
  .mm_q       (ch_addr[0]),
  .bus_vld    (ch_valid[1]),
  .bus_q      (ch_addr[1])
);

// File: tb/fault_capture_regs_test.sv
module fault_capture_regs_test;
  localparam int OFS_W = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             forced_evt = 1'b0, vecttbl_evt = 1'b0;
  logic             mm_fault = 1'b0, bus_fault = 1'b0;
  logic [31:0]      mm_addr = '0, bus_addr = '0;
  logic             reg_wr = 1'b0, reg_rd = 1'b0;
  logic [OFS_W-1:0] reg_ofs = '0;
  logic [31:0]      reg_wdata = '0;
  logic [31:0]      reg_rdata;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;
  logic rd_seen = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  fault_capture_regs #(.OFS_W(OFS_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .forced_evt(forced_evt), .vecttbl_evt(vecttbl_evt),
    .mm_fault(mm_fault), .mm_addr(mm_addr),
    .bus_fault(bus_fault), .bus_addr(bus_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_ofs(reg_ofs),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // monitor: a read sampled at a rising edge is compared at the next falling edge
  always @(posedge clk) rd_seen <= reg_rd;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R10: read result with no expected item");
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(reg_rdata, e, t);
      end
    end
  end

  // one clock cycle of stimulus, driven at a falling edge
  task automatic cyc(input bit frc, input bit vt, input bit mf, input logic [31:0] ma,
                     input bit bf, input logic [31:0] ba, input bit wr, input bit rd,
                     input int ofs, input logic [31:0] wd,
                     input logic [31:0] exp, input string tag);
    @(negedge clk);
    forced_evt = frc; vecttbl_evt = vt;
    mm_fault = mf; mm_addr = ma; bus_fault = bf; bus_addr = ba;
    reg_wr = wr; reg_rd = rd; reg_ofs = OFS_W'(ofs); reg_wdata = wd;
    if (rd) begin exp_q.push_back(exp); tag_q.push_back(tag); end
    @(negedge clk);
    forced_evt = 0; vecttbl_evt = 0; mm_fault = 0; bus_fault = 0;
    reg_wr = 0; reg_rd = 0;
  endtask

  task automatic rd(input int ofs, input logic [31:0] exp, input string tag);
    cyc(0, 0, 0, '0, 0, '0, 0, 1, ofs, '0, exp, tag);
  endtask
  task automatic wr(input int ofs, input logic [31:0] wd);
    cyc(0, 0, 0, '0, 0, '0, 1, 0, ofs, wd, '0, "");
  endtask
  task automatic mmf(input logic [31:0] a);
    cyc(0, 0, 1, a, 0, '0, 0, 0, 0, '0, '0, "");
  endtask
  task automatic busf(input logic [31:0] a);
    cyc(0, 0, 0, '0, 1, a, 0, 0, 0, '0, '0, "");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(0, 32'h0, "R1"); rd(1, 32'h0, "R1"); rd(2, 32'h0, "R1"); rd(3, 32'h0, "R1");
    rd(5, 32'h0, "R9");

    // R2 setting and stickiness
    cyc(1, 0, 0, '0, 0, '0, 0, 0, 0, '0, '0, "");
    rd(0, 32'h4000_0000, "R2");
    repeat (5) @(negedge clk);
    rd(0, 32'h4000_0000, "R2");
    cyc(0, 1, 0, '0, 0, '0, 0, 0, 0, '0, '0, "");
    rd(0, 32'h4000_0002, "R2");

    // R3 / R5 write-one-to-clear patterns
    wr(0, 32'h0);          rd(0, 32'h4000_0002, "R3");
    wr(0, 32'h8000_0000);  rd(0, 32'h4000_0002, "R5");
    wr(0, 32'h4000_0000);  rd(0, 32'h0000_0002, "R3");
    wr(0, 32'h0000_0002);  rd(0, 32'h0, "R3");

    // R4 set beats clear
    cyc(1, 0, 0, '0, 0, '0, 1, 0, 0, 32'h4000_0000, '0, "");
    rd(0, 32'h4000_0000, "R4");
    wr(0, 32'hFFFF_FFFF);  rd(0, 32'h0, "R5");

    // R10 read shows pre-edge value, then holds
    cyc(1, 0, 0, '0, 0, '0, 0, 1, 0, '0, 32'h0, "R10");
    repeat (2) @(negedge clk);
    check(reg_rdata, 32'h0, "R10");
    rd(0, 32'h4000_0000, "R10");
    wr(0, 32'hFFFF_FFFF);

    // R6 / R7 memory-management channel
    mmf(32'h1000_0003);
    rd(2, 32'h1000_0003, "R6"); rd(1, 32'h1, "R6");
    mmf(32'h2000_0000);
    rd(2, 32'h1000_0003, "R7");
    wr(2, 32'hDEAD_BEEF);  rd(2, 32'h1000_0003, "R9");
    wr(1, 32'h1);          rd(1, 32'h0, "R6"); rd(2, 32'h1000_0003, "R6");
    mmf(32'h2000_0000);    rd(2, 32'h2000_0000, "R6");

    // R8 bus channel
    busf(32'h3000_0005);
    rd(3, 32'h3000_0005, "R8"); rd(1, 32'h3, "R8");
    busf(32'h4000_0000);   rd(3, 32'h3000_0005, "R8");
    cyc(0, 0, 0, '0, 1, 32'h5000_0000, 1, 0, 1, 32'h2, '0, "");
    rd(1, 32'h3, "R4");    rd(3, 32'h3000_0005, "R4");
    wr(1, 32'h2);          rd(1, 32'h1, "R8");
    wr(3, 32'h1234_5678);  rd(3, 32'h3000_0005, "R9");
    busf(32'h5000_0000);   rd(3, 32'h5000_0000, "R8");
    rd(2, 32'h2000_0000, "R8");

    // R9 unmapped offsets
    rd(4, 32'h0, "R9"); rd(7, 32'h0, "R9");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL R10: got %0d pending reads expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule